// File: doc/BRIEF.md
# Stimulation Safety Register Controller

This block sits between a host register bus and a neural stimulation output stage. The host loads stimulation settings into shadow registers: amplitude, PWM duty, FM frequency word and global scale. The settings reach the active set only when the host writes the commit address. The active set drives two outputs. The first is a PWM waveform over a fixed 1024-cycle period. The second is a frequency-modulated carrier taken from the top bit of a phase accumulator. The block also drives an amplitude code to the analog stage.

Several safety rules are enforced in hardware, whatever the software does:
- The amplitude code saturates at 50 (1 µA per step).
- A zero global scale acts as a panic: at commit it wipes every shadow register.
- A free-running watchdog must be kicked within 5 ms.
- An external sovereignty-fail input stops stimulation at once.

A watchdog expiry or a sovereignty failure zeroes the active set and drops the output enable. Stimulation stays off until the host clears the sticky flag and commits again.

The register request channel is valid/ready. The block never back-pressures: `req_ready` is tied high, so each cycle with `req_valid` high transfers one request. A read returns its data with `rsp_valid` high in the cycle after the request is accepted. There is no response back-pressure; the host must take the data in that cycle.

Top module: `stim_safety_ctrl`

## Requirements
- R1: A write to a shadow register (address 0 amplitude, 1 duty, 2 frequency word, 3 scale) does not change `amp_o`, `pwm_o`, `fm_o` or `out_en_o`. Only a write to address 4 (commit) moves shadow values into the active set.
- R2: An accepted commit with nonzero shadow scale loads the active set and sets `out_en_o` after that clock edge. `amp_o` equals (amplitude × scale) >> 8, and scale 256 is unity.
- R3: An amplitude write above 50 stores 50 and sets the sticky clamp bit (status bit 2). Writing 1 to status bit 2 at address 6 clears it.
- R4: A scale write above 256 stores 256. Scale reads back from address 3, and its reset value is 256.
- R5: A commit while the shadow scale is 0 (panic) clears all four shadow registers to 0, zeroes the active set and drops `out_en_o`.
- R6: A write to address 5 (kick) reloads the watchdog. If no kick follows, FAULT (status bit 0, `fault_o`) rises WD_CYCLES cycles after the kick edge, where WD_CYCLES = CLK_HZ/1000 × WD_US/1000. At that point the active set is zeroed and `out_en_o` drops.
- R7: A high level on `sov_fail_i` sets SOV_FAIL (status bit 1, `sov_fail_o`), zeroes the outputs and drops the enable. The flag stays set after the input falls, until 1 is written to status bit 1.
- R8: A commit issued while FAULT or SOV_FAIL is set is ignored and the outputs stay at zero. Once the flag is cleared, a fresh commit restores stimulation. A set condition takes priority over a clear in the same cycle.
- R9: `pwm_o` is high for exactly `duty` cycles of every 1024 consecutive cycles while enabled, and low whenever `out_en_o` is low.
- R10: `fm_o` is the top bit of a 16-bit accumulator that adds the active frequency word every enabled cycle. With word 4096 it toggles 128 times in 1024 cycles. It is low when disabled.
- R11: `req_ready` is always 1. A read is answered on `rsp_valid` one cycle later. The status word reads as bit 0 FAULT, bit 1 SOV_FAIL, bit 2 clamp and bit 3 output enable. Addresses 4, 5 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request ready, always 1 |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 3 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 16 | Read data |
| sov_fail_i | input | 1 | External sovereignty failure |
| amp_o | output | 6 | Scaled amplitude code to analog stage |
| out_en_o | output | 1 | Stimulation output enable |
| pwm_o | output | 1 | PWM drive |
| fm_o | output | 1 | FM carrier |
| fault_o | output | 1 | Watchdog fault flag |
| sov_fail_o | output | 1 | Sovereignty-fail flag |

## Verification
Errors in the active set show up on `amp_o` in the cycle after the commit edge. Errors in duty or frequency need a full 1024-cycle window of counting on `pwm_o` and `fm_o`, so the bench counts over whole periods. A watchdog counter that is off by one moves the `fault_o` rise by one cycle, so the bench samples one cycle before and one cycle after the expected edge. Wrong panic or clamp handling would otherwise stay hidden in the shadow registers, so the bench reads those registers back.

// File: rtl/stim_pkg.sv
package stim_pkg;
  localparam int DW       = 16;
  localparam int AW       = 3;
  localparam int AMP_W    = 6;
  localparam int AMP_MAX  = 50;
  localparam int DUTY_W   = 10;
  localparam int FREQ_W   = 16;
  localparam int SCALE_W  = 9;
  localparam int SCALE_SH = 8;
  localparam int SCALE_ONE = 1 << SCALE_SH;

  localparam int ST_FAULT = 0;
  localparam int ST_SOV   = 1;
  localparam int ST_CLAMP = 2;
  localparam int ST_EN    = 3;

  typedef enum logic [AW-1:0] {
    A_AMP    = 3'd0,
    A_DUTY   = 3'd1,
    A_FREQ   = 3'd2,
    A_SCALE  = 3'd3,
    A_COMMIT = 3'd4,
    A_KICK   = 3'd5,
    A_STATUS = 3'd6,
    A_SPARE  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/stim_watchdog.sv
module stim_watchdog #(
  parameter int WD_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic expire
);
  localparam int CW = $clog2(WD_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WD_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  // saturates at LIMIT so expire stays asserted until a kick
  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (kick)         cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + CW'(1);
  end

  assign expire = (cnt_q == LIMIT);

  // R6
  kick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == '0));

  // R6
  count_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!kick && cnt_q != LIMIT) |=> (cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/stim_wavegen.sv
module stim_wavegen
  import stim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DUTY_W-1:0] duty,
  input  logic [FREQ_W-1:0] freq,
  output logic              pwm_o,
  output logic              fm_o
);
  logic [DUTY_W-1:0] per_q;
  logic [FREQ_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q   <= '0;
      phase_q <= '0;
    end else begin
      per_q <= per_q + DUTY_W'(1);
      if (!en) phase_q <= '0;
      else     phase_q <= phase_q + freq;
    end
  end

  assign pwm_o = en && (per_q < duty);
  assign fm_o  = en && phase_q[FREQ_W-1];

  // R9
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!pwm_o && !fm_o));

  // R10
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && en) |-> (phase_q == $past(phase_q) + $past(freq)));
endmodule

// File: rtl/stim_regfile.sv
module stim_regfile
  import stim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data,
  input  logic              wd_expire,
  input  logic              sov_fail_i,
  output logic              act_en,
  output logic [DUTY_W-1:0] act_duty,
  output logic [FREQ_W-1:0] act_freq,
  output logic [AMP_W-1:0]  amp_o,
  output logic              fault,
  output logic              sov_fail
);
  localparam int PW = AMP_W + SCALE_W;

  logic [AMP_W-1:0]   sh_amp_q,   act_amp_q;
  logic [DUTY_W-1:0]  sh_duty_q,  act_duty_q;
  logic [FREQ_W-1:0]  sh_freq_q,  act_freq_q;
  logic [SCALE_W-1:0] sh_scale_q, act_scale_q;
  logic               en_q, fault_q, sov_q, clamp_q;

  logic wr_amp, wr_duty, wr_freq, wr_scale, wr_commit, wr_status;
  logic halt_now, commit_ok, panic;

  assign wr_amp    = wr_en && (addr == A_AMP);
  assign wr_duty   = wr_en && (addr == A_DUTY);
  assign wr_freq   = wr_en && (addr == A_FREQ);
  assign wr_scale  = wr_en && (addr == A_SCALE);
  assign wr_commit = wr_en && (addr == A_COMMIT);
  assign wr_status = wr_en && (addr == A_STATUS);

  assign halt_now  = wd_expire || sov_fail_i;
  assign panic     = wr_commit && (sh_scale_q == '0);
  assign commit_ok = wr_commit && !fault_q && !sov_q && !halt_now;

  // shadow set, sticky flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_amp_q   <= '0;
      sh_duty_q  <= '0;
      sh_freq_q  <= '0;
      sh_scale_q <= SCALE_W'(SCALE_ONE);
      clamp_q    <= 1'b0;
      fault_q    <= 1'b0;
      sov_q      <= 1'b0;
    end else begin
      if (panic) begin
        sh_amp_q   <= '0;
        sh_duty_q  <= '0;
        sh_freq_q  <= '0;
        sh_scale_q <= '0;
      end else begin
        if (wr_amp)   sh_amp_q   <= (wdata > DW'(AMP_MAX)) ? AMP_W'(AMP_MAX) : wdata[AMP_W-1:0];
        if (wr_duty)  sh_duty_q  <= wdata[DUTY_W-1:0];
        if (wr_freq)  sh_freq_q  <= wdata[FREQ_W-1:0];
        if (wr_scale) sh_scale_q <= (wdata > DW'(SCALE_ONE)) ? SCALE_W'(SCALE_ONE) : wdata[SCALE_W-1:0];
      end
      clamp_q <= (wr_amp && (wdata > DW'(AMP_MAX))) || (clamp_q && !(wr_status && wdata[ST_CLAMP]));
      fault_q <= wd_expire  || (fault_q && !(wr_status && wdata[ST_FAULT]));
      sov_q   <= sov_fail_i || (sov_q   && !(wr_status && wdata[ST_SOV]));
    end
  end

  // active set
  always_ff @(posedge clk) begin
    if (!rst_n || halt_now || (commit_ok && panic)) begin
      act_amp_q   <= '0;
      act_duty_q  <= '0;
      act_freq_q  <= '0;
      act_scale_q <= '0;
      en_q        <= 1'b0;
    end else if (commit_ok) begin
      act_amp_q   <= sh_amp_q;
      act_duty_q  <= sh_duty_q;
      act_freq_q  <= sh_freq_q;
      act_scale_q <= sh_scale_q;
      en_q        <= 1'b1;
    end
  end

  // read port
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (addr)
      A_AMP:    rd_mux = DW'(sh_amp_q);
      A_DUTY:   rd_mux = DW'(sh_duty_q);
      A_FREQ:   rd_mux = DW'(sh_freq_q);
      A_SCALE:  rd_mux = DW'(sh_scale_q);
      A_STATUS: begin
        rd_mux[ST_FAULT] = fault_q;
        rd_mux[ST_SOV]   = sov_q;
        rd_mux[ST_CLAMP] = clamp_q;
        rd_mux[ST_EN]    = en_q;
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en;
      rsp_data  <= rd_en ? rd_mux : '0;
    end
  end

  logic [PW-1:0] prod;
  assign prod = {{SCALE_W{1'b0}}, act_amp_q} * {{AMP_W{1'b0}}, act_scale_q};

  assign amp_o    = prod[SCALE_SH +: AMP_W];
  assign act_en   = en_q;
  assign act_duty = act_duty_q;
  assign act_freq = act_freq_q;
  assign fault    = fault_q;
  assign sov_fail = sov_q;

  // R3
  amp_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_amp_q <= AMP_WIDTH_MAX) && (act_amp_q <= AMP_WIDTH_MAX));
  localparam logic [AMP_W-1:0] AMP_WIDTH_MAX = AMP_W'(AMP_MAX);

  // R1
  hold_without_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_commit && !halt_now) |=> ($stable(act_amp_q) && $stable(en_q)));

  // R6
  expire_to_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> (fault_q && !en_q));

  // R7
  sov_to_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sov_fail_i |=> (sov_q && !en_q && act_amp_q == '0));

  // R8
  stopped_means_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q || sov_q) |-> !en_q);

  // R5
  panic_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    panic |=> (sh_scale_q == '0 && sh_amp_q == '0 && !en_q));
endmodule

// File: rtl/stim_safety_ctrl.sv
module stim_safety_ctrl
  import stim_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int WD_US  = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data,
  input  logic              sov_fail_i,
  output logic [AMP_W-1:0]  amp_o,
  output logic              out_en_o,
  output logic              pwm_o,
  output logic              fm_o,
  output logic              fault_o,
  output logic              sov_fail_o
);
  localparam int WD_CYCLES = (CLK_HZ / 1000) * WD_US / 1000;

  logic              acc, wr_en, rd_en, kick, expire, en;
  logic [DUTY_W-1:0] duty;
  logic [FREQ_W-1:0] freq;

  assign req_ready = 1'b1;
  assign acc       = req_valid && req_ready;
  assign wr_en     = acc && req_write;
  assign rd_en     = acc && !req_write;
  assign kick      = wr_en && (req_addr == A_KICK);

  stim_watchdog #(.WD_CYCLES(WD_CYCLES)) u_wdog (
    .clk(clk), .rst_n(rst_n), .kick(kick), .expire(expire)
  );

  stim_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(req_addr), .wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wd_expire(expire), .sov_fail_i(sov_fail_i),
    .act_en(en), .act_duty(duty), .act_freq(freq), .amp_o(amp_o),
    .fault(fault_o), .sov_fail(sov_fail_o)
  );

  stim_wavegen u_wave (
    .clk(clk), .rst_n(rst_n), .en(en), .duty(duty), .freq(freq),
    .pwm_o(pwm_o), .fm_o(fm_o)
  );

  assign out_en_o = en;

  // R11
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R11
  no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
endmodule

// File: tb/sim_stim_safety_ctrl.sv
module sim_stim_safety_ctrl;
  import stim_pkg::*;

  localparam int CLK_HZ = 600_000;
  localparam int WD_US  = 5000;
  localparam int WD     = (CLK_HZ / 1000) * WD_US / 1000; // 3000

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, sov_in = 1'b0;
  logic [2:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, out_en, pwm, fm, fault, sov;
  logic [15:0] rsp_data;
  logic [5:0] amp;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  stim_safety_ctrl #(.CLK_HZ(CLK_HZ), .WD_US(WD_US)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sov_fail_i(sov_in),
    .amp_o(amp), .out_en_o(out_en), .pwm_o(pwm), .fm_o(fm),
    .fault_o(fault), .sov_fail_o(sov)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 rsp_valid", int'(rsp_valid), 1);
    d = int'(rsp_data);
  endtask

  task automatic count_window(output int hi, output int tog);
    logic prev;
    hi = 0; tog = 0;
    prev = fm;
    for (int i = 0; i < 1024; i++) begin
      if (pwm) hi++;
      @(negedge clk);
      if (fm != prev) tog++;
      prev = fm;
    end
  endtask

  task automatic t_reset();
    int d;
    check("R11 req_ready", int'(req_ready), 1);
    check("R2 reset amp", int'(amp), 0);
    check("R2 reset en", int'(out_en), 0);
    check("R6 reset fault", int'(fault), 0);
    check("R9 reset pwm", int'(pwm), 0);
    rd(3'd3, d); check("R4 reset scale", d, 256);
    rd(3'd6, d); check("R11 reset status", d, 0);
  endtask

  task automatic t_commit();
    int d, hi, tog;
    wr(3'd5, 0);
    wr(3'd0, 40); wr(3'd1, 300); wr(3'd2, 4096); wr(3'd3, 128);
    check("R1 amp before commit", int'(amp), 0);
    check("R1 en before commit", int'(out_en), 0);
    check("R1 pwm before commit", int'(pwm), 0);
    wr(3'd4, 0);
    check("R2 amp scaled", int'(amp), 20);
    check("R2 enable", int'(out_en), 1);
    wr(3'd5, 0);
    count_window(hi, tog);
    check("R9 pwm duty 300", hi, 300);
    check("R10 fm toggles", tog, 128);
    wr(3'd0, 10);
    check("R1 amp held", int'(amp), 20);
    rd(3'd4, d); check("R11 commit reads 0", d, 0);
    rd(3'd6, d); check("R11 status en bit", d, 8);
  endtask

  task automatic t_clamp();
    int d;
    wr(3'd5, 0);
    wr(3'd0, 200);
    rd(3'd0, d); check("R3 saturated amp", d, 50);
    rd(3'd6, d); check("R3 clamp bit set", (d >> 2) & 1, 1);
    wr(3'd3, 1000);
    rd(3'd3, d); check("R4 scale saturated", d, 256);
    wr(3'd4, 0);
    check("R3 amp 50 at unity", int'(amp), 50);
    wr(3'd6, 16'h4);
    rd(3'd6, d); check("R3 clamp cleared", (d >> 2) & 1, 0);
  endtask

  task automatic t_duty_edges();
    int hi, tog;
    wr(3'd5, 0);
    wr(3'd1, 0); wr(3'd4, 0);
    count_window(hi, tog);
    check("R9 duty 0", hi, 0);
    wr(3'd5, 0);
    wr(3'd1, 1023); wr(3'd4, 0);
    count_window(hi, tog);
    check("R9 duty 1023", hi, 1023);
  endtask

  task automatic t_panic();
    int d;
    wr(3'd5, 0);
    wr(3'd3, 0); wr(3'd4, 0);
    check("R5 amp zero", int'(amp), 0);
    check("R5 en off", int'(out_en), 0);
    check("R9 pwm off", int'(pwm), 0);
    check("R10 fm off", int'(fm), 0);
    rd(3'd0, d); check("R5 amp wiped", d, 0);
    rd(3'd1, d); check("R5 duty wiped", d, 0);
    rd(3'd2, d); check("R5 freq wiped", d, 0);
    rd(3'd3, d); check("R5 scale wiped", d, 0);
  endtask

  task automatic t_wdog();
    int d;
    wr(3'd0, 30); wr(3'd1, 500); wr(3'd2, 100); wr(3'd3, 256);
    wr(3'd4, 0);
    check("R2 amp 30", int'(amp), 30);
    wr(3'd5, 0);
    repeat (WD - 1) @(negedge clk);
    check("R6 no fault yet", int'(fault), 0);
    check("R6 still enabled", int'(out_en), 1);
    @(negedge clk);
    check("R6 fault rises", int'(fault), 1);
    check("R6 amp zeroed", int'(amp), 0);
    check("R6 en dropped", int'(out_en), 0);
    wr(3'd5, 0);
    wr(3'd4, 0);
    check("R8 commit ignored on fault", int'(out_en), 0);
    check("R8 amp stays zero", int'(amp), 0);
    wr(3'd6, 16'h1);
    check("R6 fault cleared", int'(fault), 0);
    wr(3'd4, 0);
    check("R8 recommit enables", int'(out_en), 1);
    check("R8 recommit amp", int'(amp), 30);
    rd(3'd6, d); check("R11 status en only", d, 8);
  endtask

  task automatic t_sov();
    wr(3'd5, 0);
    @(negedge clk); sov_in = 1'b1;
    @(negedge clk); sov_in = 1'b0;
    check("R7 sov flag", int'(sov), 1);
    check("R7 en dropped", int'(out_en), 0);
    check("R7 amp zero", int'(amp), 0);
    repeat (5) @(negedge clk);
    check("R7 flag sticky", int'(sov), 1);
    wr(3'd4, 0);
    check("R8 commit ignored on sov", int'(out_en), 0);
    wr(3'd6, 16'h2);
    check("R7 flag cleared", int'(sov), 0);
    wr(3'd4, 0);
    check("R8 restored after sov", int'(out_en), 1);
    check("R8 amp after sov", int'(amp), 30);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_commit();
    t_clamp();
    t_duty_edges();
    t_panic();
    t_wdog();
    t_sov();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule